// File: doc/BRIEF.md
# Resonator Notch Cell for Harmonic Separation

This block is a single cell of a filter bank that separates a converted test tone into its fundamental, its harmonics and the remaining noise. Each accepted ADC sample drives a second-order bandpass resonator built in transposed form. The cell returns two results. The first is the resonator output, which keeps the band around the programmed resonance. The second is the input minus that output, a notch that removes the same band. Cells are chained by feeding one cell's notch output into the next cell.

The resonance is set at run time by one signed coefficient, `coefA1`. It is coded with 1 integer bit and 16 fractional bits, and it is the only value that passes through a real multiplier. The pole radius is fixed at build time, so the numerator gain and the second feedback coefficient reduce to an arithmetic shift and a shift-and-subtract. The zeros sit at DC and at half the sample rate. Each sample is first moved into a 29-bit word that carries 12 integer bits and 16 fractional bits. The feedback path keeps 3 more guard bits.

Top module: `notch_cell`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `outValid` = 0, `bandOut` = 0 and `notchOut` = 0, and both resonator states are cleared.
- R2: `outValid` is high in exactly the cycle after each cycle in which `inValid` is high, and it is low in every other cycle.
- R3: With x = sample·2^16 and bx = x >>> 4, the output is y = bx + s1. The states then update to s1' = s2 − ((coefA1·y) >>> 16) and s2' = −bx − (y − (y >>> 4)). Every shift is arithmetic, and all values are two's complement and wrap at 32 bits. `bandOut` is the low 29 bits of y.
- R4: `notchOut` equals the low 29 bits of x − y for the same sample, so `notchOut` + `bandOut` ≡ x modulo 2^29.
- R5: In cycles without `inValid`, both outputs hold their values and the states do not change.
- R6: `inSample` and `coefA1` are read only in cycles with `inValid` high. Their values in other cycles have no effect on any later output.
- R7: The first sample after reset gives `bandOut` = sample·2^12, because both states start at zero.
- R8: A reset in the middle of a stream discards all history. The next sample behaves exactly like the first sample after power-up.
- R9: Every 18-bit `coefA1` code is accepted, from −2.0 (0x20000) to just under +2.0 (0x1FFFF). Unstable settings wrap as stated in R3 and do not saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks a sample to be accepted |
| inSample | input | 12 | Signed ADC sample |
| coefA1 | input | 18 | Signed frequency coefficient, 1.16 format |
| outValid | output | 1 | Marks a new result |
| bandOut | output | 29 | Resonator output, signed 12.16 |
| notchOut | output | 29 | Input minus resonator output, signed 12.16 |

## Verification
The hardest situation to reach is arithmetic wrap inside the feedback states. A stable coefficient never drives the guard bits. The stimulus therefore runs bursts at the extreme coefficient codes with full-scale alternating samples, which pushes the states into wrap. The model wraps at the same width, so the bit-exact comparison still holds. Idle gaps carry random junk on the sample and coefficient pins, which shows that only qualified cycles move the recursion.

// File: rtl/notch_pkg.sv
package notch_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic clearAll;
    logic stateEn;
    logic outEn;
  } cellCtrl_t;

endpackage

// File: rtl/notch_shift_scale.sv
// Multiplier-free scaling: either x*2^-SHIFT or x*(1-2^-SHIFT)
module notch_shift_scale #(
  parameter int W        = 32,
  parameter int SHIFT    = 4,
  parameter bit SUBTRACT = 1'b0
) (
  input  logic signed [W-1:0] valIn,
  output logic signed [W-1:0] valOut
);

  generate
    if (SUBTRACT) begin : g_sub
      assign valOut = valIn - (valIn >>> SHIFT);
    end else begin : g_shift
      assign valOut = valIn >>> SHIFT;
    end
  endgenerate

endmodule

// File: rtl/notch_coef_mult.sv
// Signed data times signed fixed-point coefficient, fraction truncated
module notch_coef_mult #(
  parameter int ACC_W  = 32,
  parameter int COEF_W = 18,
  parameter int FRAC_W = 16
) (
  input  logic signed [ACC_W-1:0]  dataIn,
  input  logic signed [COEF_W-1:0] coefIn,
  output logic signed [ACC_W-1:0]  prodOut
);

  localparam int PROD_W = ACC_W + COEF_W;

  logic signed [PROD_W-1:0] fullProd;
  logic unusedProdBits;

  assign fullProd = PROD_W'(dataIn) * PROD_W'(coefIn);
  assign prodOut  = fullProd[FRAC_W +: ACC_W];
  assign unusedProdBits = ^{fullProd[FRAC_W-1:0], fullProd[PROD_W-1:FRAC_W+ACC_W]};

endmodule

// File: rtl/notch_ctrl.sv
module notch_ctrl
  import notch_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output cellCtrl_t ctrl,
  output logic      outValid
);

  logic validQ;

  always_comb begin
    ctrl.clearAll = rst;
    ctrl.stateEn  = inValid & ~rst;
    ctrl.outEn    = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= inValid;
  end

  assign outValid = validQ;

endmodule

// File: rtl/notch_datapath.sv
module notch_datapath
  import notch_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 18,
  parameter int FRAC_W   = 16,
  parameter int GUARD_W  = 3,
  parameter int B0_SHIFT = 4,
  parameter int A2_SHIFT = 4,
  localparam int DATA_W  = SAMPLE_W + FRAC_W + 1
) (
  input  logic                clk,
  input  cellCtrl_t           ctrl,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [COEF_W-1:0]   coefIn,
  output logic [DATA_W-1:0]   bandOut,
  output logic [DATA_W-1:0]   notchOut
);

  localparam int ACC_W = DATA_W + GUARD_W;
  localparam int EXT_W = ACC_W - SAMPLE_W - FRAC_W;

  logic signed [ACC_W-1:0] xWide, bxScaled, yNow, a1Term, a2Term;
  logic signed [ACC_W-1:0] s1Q, s2Q, s1Next, s2Next, notchWide;
  logic [DATA_W-1:0] bandQ, notchQ;
  logic unusedHighBits;

  assign xWide = {{EXT_W{sampleIn[SAMPLE_W-1]}}, sampleIn, {FRAC_W{1'b0}}};

  notch_shift_scale #(.W(ACC_W), .SHIFT(B0_SHIFT), .SUBTRACT(1'b0)) b0_i (
    .valIn (xWide),
    .valOut(bxScaled)
  );

  assign yNow = bxScaled + s1Q;

  notch_coef_mult #(.ACC_W(ACC_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) a1_i (
    .dataIn (yNow),
    .coefIn ($signed(coefIn)),
    .prodOut(a1Term)
  );

  notch_shift_scale #(.W(ACC_W), .SHIFT(A2_SHIFT), .SUBTRACT(1'b1)) a2_i (
    .valIn (yNow),
    .valOut(a2Term)
  );

  assign s1Next    = s2Q - a1Term;
  assign s2Next    = -bxScaled - a2Term;
  assign notchWide = xWide - yNow;
  assign unusedHighBits = ^{yNow[ACC_W-1:DATA_W], notchWide[ACC_W-1:DATA_W]};

  always_ff @(posedge clk) begin
    if (ctrl.clearAll) begin
      s1Q    <= '0;
      s2Q    <= '0;
      bandQ  <= '0;
      notchQ <= '0;
    end else begin
      if (ctrl.stateEn) begin
        s1Q <= s1Next;
        s2Q <= s2Next;
      end
      if (ctrl.outEn) begin
        bandQ  <= yNow[DATA_W-1:0];
        notchQ <= notchWide[DATA_W-1:0];
      end
    end
  end

  assign bandOut  = bandQ;
  assign notchOut = notchQ;

endmodule

// File: rtl/notch_cell.sv
module notch_cell
  import notch_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 18,
  parameter int FRAC_W   = 16,
  parameter int GUARD_W  = 3,
  parameter int B0_SHIFT = 4,
  parameter int A2_SHIFT = 4,
  localparam int DATA_W  = SAMPLE_W + FRAC_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic [COEF_W-1:0]   coefA1,
  output logic                outValid,
  output logic [DATA_W-1:0]   bandOut,
  output logic [DATA_W-1:0]   notchOut
);

  cellCtrl_t ctrl;

  notch_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .ctrl    (ctrl),
    .outValid(outValid)
  );

  notch_datapath #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
    .GUARD_W(GUARD_W), .B0_SHIFT(B0_SHIFT), .A2_SHIFT(A2_SHIFT)
  ) dp_i (
    .clk     (clk),
    .ctrl    (ctrl),
    .sampleIn(inSample),
    .coefIn  (coefA1),
    .bandOut (bandOut),
    .notchOut(notchOut)
  );

endmodule

// File: rtl/notch_cell_chk.sv
module notch_cell_chk #(
  parameter int SAMPLE_W = 12,
  parameter int FRAC_W   = 16,
  parameter int B0_SHIFT = 4,
  parameter int DATA_W   = 29
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic [SAMPLE_W-1:0] inSample,
  input logic                outValid,
  input logic [DATA_W-1:0]   bandOut,
  input logic [DATA_W-1:0]   notchOut
);

  logic [DATA_W-1:0] xAligned, firstBand, sumOut;
  logic fresh;

  assign xAligned  = {{(DATA_W-SAMPLE_W-FRAC_W){inSample[SAMPLE_W-1]}}, inSample, {FRAC_W{1'b0}}};
  assign firstBand = {{(DATA_W-SAMPLE_W-FRAC_W+B0_SHIFT){inSample[SAMPLE_W-1]}}, inSample,
                      {(FRAC_W-B0_SHIFT){1'b0}}};
  assign sumOut    = notchOut + bandOut;

  always_ff @(posedge clk) begin
    if (rst)          fresh <= 1'b1;
    else if (inValid) fresh <= 1'b0;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!outValid && bandOut == '0 && notchOut == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  a_r4_notch_complements: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) || outValid |-> sumOut == $past(xAligned));

  a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!outValid && !$past(rst)) |-> ($stable(bandOut) && $stable(notchOut)));

  a_r7_first_sample: assert property (@(posedge clk) disable iff (rst)
    (fresh && inValid) |=> bandOut == $past(firstBand));

endmodule

bind notch_cell notch_cell_chk #(
  .SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .B0_SHIFT(B0_SHIFT), .DATA_W(DATA_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inSample(inSample),
  .outValid(outValid),
  .bandOut (bandOut),
  .notchOut(notchOut)
);

// File: tb/notch_cell_tb_top.sv
`timescale 1ns/1ps
module notch_cell_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [11:0] inSample = '0;
  logic [17:0] coefA1 = '0;
  logic        outValid;
  logic [28:0] bandOut, notchOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  longint mS1 = 0, mS2 = 0;

  always #2 clk = ~clk;

  notch_cell dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .coefA1(coefA1), .outValid(outValid), .bandOut(bandOut), .notchOut(notchOut)
  );

  function automatic longint wrapAcc(input longint v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one accepted sample; expected values from the R3/R4 equations
  task automatic push(input logic [11:0] s, input logic [17:0] a, input string tag);
    longint x, bx, y, p, pt, a2y, n1, n2;
    x   = $signed(s);
    x   = x <<< 16;
    bx  = x >>> 4;
    y   = wrapAcc(bx + mS1);
    p   = longint'($signed(a)) * y;
    pt  = wrapAcc(p >>> 16);
    a2y = wrapAcc(y - (y >>> 4));
    n1  = wrapAcc(mS2 - pt);
    n2  = wrapAcc(-bx - a2y);
    inValid  = 1'b1;
    inSample = s;
    coefA1   = a;
    @(negedge clk);
    inValid = 1'b0;
    check("R2 outValid", 64'(outValid), 64'd1);
    check(tag, 64'(bandOut), 64'(y[28:0]));
    check("R4 notch", 64'(notchOut), 64'(wrapAcc(x - y) & 64'h1FFF_FFFF));
    mS1 = n1;
    mS2 = n2;
  endtask

  // idle cycles with junk on the data pins (R5, R6)
  task automatic gap(input int n);
    logic [28:0] b0, n0;
    b0 = bandOut;
    n0 = notchOut;
    for (int i = 0; i < n; i++) begin
      inValid  = 1'b0;
      inSample = 12'($urandom);
      coefA1   = 18'($urandom);
      @(negedge clk);
      check("R2 idle outValid", 64'(outValid), 64'd0);
      check("R5 band hold", 64'(bandOut), 64'(b0));
      check("R5 notch hold", 64'(notchOut), 64'(n0));
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mS1 = 0;
    mS2 = 0;
  endtask

  initial begin
    int seedVal;
    int g;
    logic [17:0] aRes;
    seedVal = $urandom(32'd5150);
    aRes = 18'(-102640);
    repeat (3) @(negedge clk);
    check("R1 outValid", 64'(outValid), 64'd0);
    check("R1 band", 64'(bandOut), 64'd0);
    check("R1 notch", 64'(notchOut), 64'd0);
    rst = 1'b0;
    mS1 = 0;
    mS2 = 0;
    @(negedge clk);

    // impulse: first sample after reset then ringing
    push(12'h7FF, aRes, "R7 first band");
    for (int i = 0; i < 12; i++) push(12'h000, aRes, "R3 ringing");
    // DC step
    for (int i = 0; i < 10; i++) push(12'h7FF, aRes, "R3 dc step");
    // random samples, coefficients and gaps
    for (int i = 0; i < 250; i++) begin
      if (i % 25 == 0) aRes = 18'($signed(int'($urandom_range(0, 252000))) - 126000);
      g = int'($urandom_range(0, 2));
      if (g != 0) begin
        gap(g);
        push(12'($urandom), aRes, "R6 after gap");
      end else begin
        push(12'($urandom), aRes, "R3 random");
      end
    end
    // mid-stream reset
    inValid = 1'b1;
    doReset();
    inValid = 1'b0;
    check("R8 band cleared", 64'(bandOut), 64'd0);
    check("R8 valid cleared", 64'(outValid), 64'd0);
    @(negedge clk);
    push(12'h800, aRes, "R8 first band");
    push(12'h123, aRes, "R8 second band");
    // extreme coefficient codes driving the states into wrap
    for (int i = 0; i < 40; i++) push((i % 2) ? 12'h800 : 12'h7FF, 18'h20000, "R9 a1 min");
    doReset();
    @(negedge clk);
    for (int i = 0; i < 40; i++) push((i % 2) ? 12'h800 : 12'h7FF, 18'h1FFFF, "R9 a1 max");
    for (int i = 0; i < 10; i++) push(12'($urandom), 18'h00000, "R9 a1 zero");
    gap(3);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule